// File: doc/BRIEF.md
# Delay-Slot-Aware Exception PC Capture

This block sits beside a five-stage in-order pipeline that has a single branch delay slot. It keeps a small shadow record for every instruction moving through the decode, execute and memory stages: a valid bit, the instruction address, the first exception cause raised so far, and a flag that marks the instruction as occupying a delay slot. The flag is set at fetch whenever decode resolves a jump or a taken branch in that same cycle. It then travels unchanged with the instruction.

Exceptions are acted upon only when the faulting instruction reaches the memory stage. In that cycle the block raises a one-cycle exception strobe. It presents the saved return address, the cause code and the delay-slot flag. When the faulting instruction sits in a delay slot, the return address is that of the jump or branch just ahead of it, one word lower. The block also pulses flush strobes for fetch, decode and execute and empties its own records for those stages. It redirects the program counter to the address of the instruction that was in execute.

Top module: `dsx_pc_capture`

## Requirements
- R1: After reset all stage records are empty, and exc_valid_o, every flush strobe and redirect_valid_o are low until an exception is raised.
- R2: An instruction presented at fetch with fetch_valid_i high, in a cycle where jb_resolve_i is high while decode holds a valid instruction and stall_i is low, is tagged as a delay-slot instruction. exc_bd_o is 1 exactly when the excepting instruction carries that tag.
- R3: The tag, address and cause move unchanged from stage to stage. An empty record always has a clear tag, address 0 and cause 0.
- R4: The cause value 0 means no exception. The earliest nonzero cause wins. The priority order is fetch_cause_i, then dec_cause_i (applied to the decode record), then exe_cause_i (applied to the execute record), then mem_cause_i (applied to the memory record). Causes injected into an empty record are ignored.
- R5: exc_valid_o is high for exactly the cycle in which the memory record is valid with a nonzero effective cause. With no stalls, an instruction fetched in cycle t raises it in cycle t+3. A memory-stage exception is taken even while stall_i is high.
- R6: exc_epc_o equals the excepting address minus 4 when the instruction is tagged, and the excepting address itself otherwise. exc_cause_o is the winning 5-bit cause.
- R7: During an exception, flush_fetch_o, flush_decode_o and flush_execute_o are high. In the next cycle the decode, execute and memory records are empty, so no instruction that was in flight raises an exception.
- R8: During an exception, redirect_valid_o is high and redirect_pc_o is the address of the instruction in the execute record.
- R9: While stall_i is high and no exception is taken, no record changes and a resolved jump or branch tags nothing.
- R10: In every cycle without an exception, redirect_valid_o and all flush strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall_i | input | 1 | Pipeline stall; holds all records |
| fetch_valid_i | input | 1 | Fetch stage holds an instruction |
| fetch_addr_i | input | 32 | Address of the fetched instruction |
| fetch_cause_i | input | 5 | Cause raised at fetch (0 = none) |
| jb_resolve_i | input | 1 | Decode resolves a jump or taken branch |
| dec_cause_i | input | 5 | Cause raised by the decode-stage instruction |
| exe_cause_i | input | 5 | Cause raised by the execute-stage instruction |
| mem_cause_i | input | 5 | Cause raised by the memory-stage instruction |
| exc_valid_o | output | 1 | One-cycle exception strobe |
| exc_epc_o | output | 32 | Saved return address |
| exc_cause_o | output | 5 | Exception cause code |
| exc_bd_o | output | 1 | Excepting instruction was in a delay slot |
| flush_fetch_o | output | 1 | Discard fetch stage |
| flush_decode_o | output | 1 | Discard decode stage |
| flush_execute_o | output | 1 | Discard execute stage |
| redirect_valid_o | output | 1 | Load the program counter |
| redirect_pc_o | output | 32 | Program counter value to load |

## Verification
Directed sequences place a fault in the slot right after a resolved jump and a fault on an ordinary instruction. Comparing exc_epc_o across the two separates the minus-one-word path from the own-address path. A third sequence raises causes in several stages for the same instruction, which exposes any wrong priority among them. A further sequence resolves a jump during a stall, which shows whether a held cycle wrongly tags an instruction. A sequence with a fault queued behind an earlier one shows whether the flush really empties every in-flight record. Long pseudo-random runs with frequent stalls, jumps and sparse or dense causes are then compared on every cycle against a behavioural model. Those runs catch timing slips in the t+3 path and faults taken during stalls.

// File: rtl/dsx_pkg.sv
package dsx_pkg;
  parameter int ADDR_W = 32;
  parameter int CAUSE_W = 5;
  localparam int WORD_BYTES = 4;

  typedef logic [ADDR_W-1:0]  addr_t;
  typedef logic [CAUSE_W-1:0] cause_t;

  localparam cause_t CAUSE_NONE = '0;

  // One shadow record per pipeline stage
  typedef struct packed {
    logic   valid;
    logic   bd;
    cause_t cause;
    addr_t  addr;
  } slot_t;

  function automatic slot_t slot_empty();
    return '0;
  endfunction

  // Advance a record by one stage and merge in a cause raised there.
  // An older cause always wins; empty records stay empty.
  function automatic slot_t slot_carry(slot_t s, cause_t inj);
    slot_t r;
    if (!s.valid) begin
      r = slot_empty();
    end else begin
      r = s;
      if (r.cause == CAUSE_NONE) r.cause = inj;
    end
    return r;
  endfunction

  // Return address: one word back when the instruction is in a delay slot
  function automatic addr_t epc_of(addr_t a, logic bd);
    return bd ? a - addr_t'(WORD_BYTES) : a;
  endfunction
endpackage

// File: rtl/dsx_slot_tag.sv
module dsx_slot_tag
  import dsx_pkg::*;
(
  input  logic   fetch_valid,
  input  addr_t  fetch_addr,
  input  cause_t fetch_cause,
  input  logic   jb_resolve,
  input  logic   dec_valid,
  output slot_t  fetch_slot,
  output logic   tag_event
);
  // A jump or taken branch resolving in decode marks the instruction fetched now
  assign tag_event = jb_resolve && dec_valid && fetch_valid;

  always_comb begin
    fetch_slot = slot_empty();
    if (fetch_valid) begin
      fetch_slot.valid = 1'b1;
      fetch_slot.bd    = tag_event;
      fetch_slot.cause = fetch_cause;
      fetch_slot.addr  = fetch_addr;
    end
  end
endmodule

// File: rtl/dsx_stage_reg.sv
module dsx_stage_reg
  import dsx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  hold,
  input  logic  flush,
  input  slot_t d,
  output slot_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= slot_empty();
    else if (flush)  q <= slot_empty();
    else if (!hold)  q <= d;
  end

  // R9
  hold_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold && !flush |=> $stable(q));

  // R3
  empty_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !q.valid |-> (q.cause == CAUSE_NONE && !q.bd && q.addr == '0));
endmodule

// File: rtl/dsx_exc_ctrl.sv
module dsx_exc_ctrl
  import dsx_pkg::*;
(
  input  slot_t  mem_slot,
  input  cause_t mem_inj,
  input  addr_t  exe_addr,
  output logic   exc_take,
  output addr_t  exc_epc,
  output cause_t exc_cause,
  output logic   exc_bd,
  output logic   flush_f,
  output logic   flush_d,
  output logic   flush_e,
  output logic   redirect_valid,
  output addr_t  redirect_pc
);
  slot_t mem_eff;

  assign mem_eff  = slot_carry(mem_slot, mem_inj);
  assign exc_take = mem_eff.valid && (mem_eff.cause != CAUSE_NONE);

  assign exc_epc   = exc_take ? epc_of(mem_eff.addr, mem_eff.bd) : '0;
  assign exc_cause = exc_take ? mem_eff.cause : CAUSE_NONE;
  assign exc_bd    = exc_take && mem_eff.bd;

  assign flush_f        = exc_take;
  assign flush_d        = exc_take;
  assign flush_e        = exc_take;
  assign redirect_valid = exc_take;
  assign redirect_pc    = exc_take ? exe_addr : '0;
endmodule

// File: rtl/dsx_pc_capture.sv
module dsx_pc_capture
  import dsx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                stall_i,
  input  logic                fetch_valid_i,
  input  logic [ADDR_W-1:0]   fetch_addr_i,
  input  logic [CAUSE_W-1:0]  fetch_cause_i,
  input  logic                jb_resolve_i,
  input  logic [CAUSE_W-1:0]  dec_cause_i,
  input  logic [CAUSE_W-1:0]  exe_cause_i,
  input  logic [CAUSE_W-1:0]  mem_cause_i,
  output logic                exc_valid_o,
  output logic [ADDR_W-1:0]   exc_epc_o,
  output logic [CAUSE_W-1:0]  exc_cause_o,
  output logic                exc_bd_o,
  output logic                flush_fetch_o,
  output logic                flush_decode_o,
  output logic                flush_execute_o,
  output logic                redirect_valid_o,
  output logic [ADDR_W-1:0]   redirect_pc_o
);
  // Records for decode, execute and memory
  localparam int NSTG = 3;
  localparam int ST_D = 0;
  localparam int ST_E = 1;
  localparam int ST_M = 2;

  slot_t  stg_d [NSTG];
  slot_t  stg_q [NSTG];
  cause_t stg_inj [NSTG-1];
  slot_t  fetch_slot;
  logic   tag_event;
  logic   exc_take;

  assign stg_inj[ST_D] = dec_cause_i;
  assign stg_inj[ST_E] = exe_cause_i;

  dsx_slot_tag tag_i (
    .fetch_valid (fetch_valid_i),
    .fetch_addr  (fetch_addr_i),
    .fetch_cause (fetch_cause_i),
    .jb_resolve  (jb_resolve_i),
    .dec_valid   (stg_q[ST_D].valid),
    .fetch_slot  (fetch_slot),
    .tag_event   (tag_event)
  );

  for (genvar i = 0; i < NSTG; i++) begin : g_stage
    if (i == 0) begin : g_first
      assign stg_d[i] = fetch_slot;
    end else begin : g_next
      assign stg_d[i] = slot_carry(stg_q[i-1], stg_inj[i-1]);
    end
    dsx_stage_reg reg_i (
      .clk   (clk),
      .rst_n (rst_n),
      .hold  (stall_i),
      .flush (exc_take),
      .d     (stg_d[i]),
      .q     (stg_q[i])
    );
  end

  dsx_exc_ctrl ctrl_i (
    .mem_slot       (stg_q[ST_M]),
    .mem_inj        (mem_cause_i),
    .exe_addr       (stg_q[ST_E].addr),
    .exc_take       (exc_take),
    .exc_epc        (exc_epc_o),
    .exc_cause      (exc_cause_o),
    .exc_bd         (exc_bd_o),
    .flush_f        (flush_fetch_o),
    .flush_d        (flush_decode_o),
    .flush_e        (flush_execute_o),
    .redirect_valid (redirect_valid_o),
    .redirect_pc    (redirect_pc_o)
  );

  assign exc_valid_o = exc_take;

  // R7
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid_o |=> (!stg_q[ST_D].valid && !stg_q[ST_E].valid && !stg_q[ST_M].valid));

  // R5
  exc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid_o |=> !exc_valid_o);

  // R2
  tag_needs_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tag_event && !stall_i && !exc_take |=> (stg_q[ST_D].bd && stg_q[ST_D].valid));

  // R10
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_valid_o |-> (!redirect_valid_o && !flush_fetch_o && !flush_decode_o && !flush_execute_o));
endmodule

// File: tb/dsx_pc_capture_tb_top.sv
`timescale 1ns/1ps
module dsx_pc_capture_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stall_i = 1'b0;
  logic        fetch_valid_i = 1'b0;
  logic [31:0] fetch_addr_i = '0;
  logic [4:0]  fetch_cause_i = '0;
  logic        jb_resolve_i = 1'b0;
  logic [4:0]  dec_cause_i = '0;
  logic [4:0]  exe_cause_i = '0;
  logic [4:0]  mem_cause_i = '0;
  logic        exc_valid_o;
  logic [31:0] exc_epc_o;
  logic [4:0]  exc_cause_o;
  logic        exc_bd_o;
  logic        flush_fetch_o, flush_decode_o, flush_execute_o;
  logic        redirect_valid_o;
  logic [31:0] redirect_pc_o;

  always #5 clk = ~clk;

  dsx_pc_capture dut_i (
    .clk(clk), .rst_n(rst_n), .stall_i(stall_i),
    .fetch_valid_i(fetch_valid_i), .fetch_addr_i(fetch_addr_i),
    .fetch_cause_i(fetch_cause_i), .jb_resolve_i(jb_resolve_i),
    .dec_cause_i(dec_cause_i), .exe_cause_i(exe_cause_i), .mem_cause_i(mem_cause_i),
    .exc_valid_o(exc_valid_o), .exc_epc_o(exc_epc_o), .exc_cause_o(exc_cause_o),
    .exc_bd_o(exc_bd_o), .flush_fetch_o(flush_fetch_o), .flush_decode_o(flush_decode_o),
    .flush_execute_o(flush_execute_o), .redirect_valid_o(redirect_valid_o),
    .redirect_pc_o(redirect_pc_o)
  );

  int ncmp = 0;
  int nbad = 0;
  bit done = 0;

  // Behavioural model: index 0 = decode, 1 = execute, 2 = memory
  int          mv [3];
  int          mb [3];
  int          mc [3];
  logic [31:0] ma [3];
  int          m_exc;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    ncmp++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 3; i++) begin
      mv[i] = 0; mb[i] = 0; mc[i] = 0; ma[i] = '0;
    end
  endtask

  task automatic cyc(input bit fv, input logic [31:0] fa, input int fc, input bit jb,
                     input bit st, input int dc, input int ec, input int mci);
    int eff;
    logic [31:0] exp_epc;
    @(negedge clk);
    fetch_valid_i = fv; fetch_addr_i = fa; fetch_cause_i = 5'(fc);
    jb_resolve_i = jb; stall_i = st;
    dec_cause_i = 5'(dc); exe_cause_i = 5'(ec); mem_cause_i = 5'(mci);
    #1;
    eff = (mc[2] != 0) ? mc[2] : mci;
    m_exc = (mv[2] != 0 && eff != 0) ? 1 : 0;
    exp_epc = (mb[2] != 0) ? ma[2] - 32'd4 : ma[2];
    chk("R5 exc_valid", 32'(exc_valid_o), 32'(m_exc));
    chk("R7 flush_fetch", 32'(flush_fetch_o), 32'(m_exc));
    chk("R7 flush_decode", 32'(flush_decode_o), 32'(m_exc));
    chk("R7 flush_execute", 32'(flush_execute_o), 32'(m_exc));
    chk("R10 redirect_valid", 32'(redirect_valid_o), 32'(m_exc));
    if (m_exc != 0) begin
      chk("R6 epc", exc_epc_o, exp_epc);
      chk("R4 cause", 32'(exc_cause_o), 32'(eff));
      chk("R2 bd", 32'(exc_bd_o), 32'(mb[2]));
      chk("R8 redirect_pc", redirect_pc_o, ma[1]);
    end
    // state after the coming edge
    if (m_exc != 0) begin
      model_clear();
    end else if (!st) begin
      for (int i = 2; i >= 1; i--) begin
        int inj;
        inj = (i == 2) ? ec : dc;
        if (mv[i-1] != 0) begin
          mv[i] = 1; mb[i] = mb[i-1]; ma[i] = ma[i-1];
          mc[i] = (mc[i-1] != 0) ? mc[i-1] : inj;
        end else begin
          mv[i] = 0; mb[i] = 0; mc[i] = 0; ma[i] = '0;
        end
      end
      if (fv) begin
        mb[0] = (jb && mv[0] != 0) ? 1 : 0;
        mv[0] = 1; ma[0] = fa; mc[0] = fc;
      end else begin
        mv[0] = 0; mb[0] = 0; mc[0] = 0; ma[0] = '0;
      end
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #500000;
    if (!done) begin
      ncmp++; nbad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
      $finish;
    end
  end

  initial begin
    logic [31:0] pc;
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: quiet after reset
    idle(2);
    chk("R1 exc_valid after reset", 32'(exc_valid_o), 0);
    chk("R1 flush after reset", 32'(flush_fetch_o | flush_decode_o | flush_execute_o), 0);
    chk("R1 redirect after reset", 32'(redirect_valid_o), 0);

    // Delay-slot fault: jump at 0x100, slot 0x104 faults, 0x108 faults later
    cyc(1, 32'h100, 0, 0, 0, 0, 0, 0);
    cyc(1, 32'h104, 5, 1, 0, 0, 0, 0);
    cyc(1, 32'h108, 7, 0, 0, 0, 0, 0);
    cyc(1, 32'h10C, 0, 0, 0, 0, 0, 0);
    cyc(1, 32'h110, 0, 0, 0, 0, 0, 0);
    chk("R5 fault at t+3", 32'(exc_valid_o), 1);
    chk("R2 bd set for slot", 32'(exc_bd_o), 1);
    chk("R6 epc is jump address", exc_epc_o, 32'h100);
    chk("R6 cause", 32'(exc_cause_o), 5);
    chk("R8 redirect to execute addr", redirect_pc_o, 32'h108);
    for (int k = 0; k < 4; k++) begin
      cyc(0, 0, 0, 0, 0, 0, 0, 0);
      chk("R7 flushed fault never raised", 32'(exc_valid_o), 0);
    end

    // Jump resolved during stall tags nothing; fault taken during stall
    cyc(1, 32'h200, 0, 0, 0, 0, 0, 0);
    cyc(1, 32'h204, 6, 1, 1, 0, 0, 0);
    cyc(1, 32'h204, 6, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 0, 0, 0);
    chk("R9 stall delays fault", 32'(exc_valid_o), 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 0, 0, 0);
    chk("R5 fault taken while stalled", 32'(exc_valid_o), 1);
    chk("R9 no tag from stalled jump", 32'(exc_bd_o), 0);
    chk("R6 epc own address", exc_epc_o, 32'h204);
    idle(2);

    // Cause priority across stages
    cyc(1, 32'h300, 2, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 4, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 6, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 9);
    chk("R4 fetch cause wins", 32'(exc_cause_o), 2);
    cyc(1, 32'h400, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 4, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 6, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 9);
    chk("R4 decode cause wins", 32'(exc_cause_o), 4);
    cyc(1, 32'h500, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 9);
    chk("R4 memory cause alone", 32'(exc_cause_o), 9);
    chk("R3 address carried", exc_epc_o, 32'h500);
    // cause into empty records ignored
    cyc(0, 0, 0, 0, 0, 3, 3, 3);
    chk("R4 empty record ignores cause", 32'(exc_valid_o), 0);

    // Random traffic, sparse then dense faults
    pc = 32'h1000;
    for (int ph = 0; ph < 2; ph++) begin
      for (int k = 0; k < 4000; k++) begin
        bit fv, jb, st;
        int fc, dc, ec, mci, lim;
        lim = (ph == 0) ? 3 : 25;
        fv = ($urandom_range(99) < 85);
        jb = ($urandom_range(99) < 30);
        st = ($urandom_range(99) < 20);
        fc = ($urandom_range(99) < lim) ? int'($urandom_range(31, 1)) : 0;
        dc = ($urandom_range(99) < lim) ? int'($urandom_range(31, 1)) : 0;
        ec = ($urandom_range(99) < lim) ? int'($urandom_range(31, 1)) : 0;
        mci = ($urandom_range(99) < lim) ? int'($urandom_range(31, 1)) : 0;
        cyc(fv, pc, fc, jb, st, dc, ec, mci);
        if (!st) pc = pc + 32'd4;
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
    $finish;
  end
endmodule